// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns one operand reference into a linear address. The reference is a base register value, an index register value with a two-bit scale code, and a displacement. The block adds these to form an offset, then adds the base of the selected segment to that offset. A fault code comes back with the address. All address arithmetic wraps modulo 2^32.

The mode input selects how the segment is read. With the mode input low (real mode), the segment input is a 16-bit paragraph number, and the segment base is that number times 16. The segment limit is fixed at 64 KB. With the mode input high (protected mode), a cached descriptor supplies the segment. It gives a 32-bit base, a 20-bit limit, a granularity bit that scales the limit to 4 KB units, and a present bit. An access whose last byte lies beyond the limit raises the general-protection exception. A descriptor that is not present raises the not-present exception instead.

The result is registered, so the outputs present the answer to the inputs one clock edge after they are sampled. The usual use is as the address stage of an execution pipeline, which feeds the next stage with the linear address and any fault.

Top module: `seg_addr_gen`

## Requirements
- R1: The offset is (base_val when base_use=1, else 0) + (index_val shifted left by scale_code when index_use=1, else 0) + disp, taken modulo 2^32. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R2: When prot_mode=0, lin_addr = (seg_para × 16) + offset, modulo 2^32.
- R3: When prot_mode=0, gp_fault=1 and exc_code=13 exactly when offset + acc_size > 0xFFFF. Here acc_size is the access length minus one. The sum is computed without wrap. In this mode desc_present, desc_gran, desc_base and desc_limit have no effect, and np_fault stays 0.
- R4: When prot_mode=1, lin_addr = desc_base + offset, modulo 2^32.
- R5: When prot_mode=1, the effective limit depends on desc_gran. With desc_gran=0 it is desc_limit in bytes. With desc_gran=1 it is desc_limit × 4096 + 4095.
- R6: When prot_mode=1 and desc_present=1, gp_fault=1 and exc_code=13 exactly when offset + acc_size, computed without wrap, exceeds the effective limit.
- R7: When prot_mode=1 and desc_present=0, np_fault=1, exc_code=11 and gp_fault=0, whatever the limit check gives.
- R8: When neither fault is raised, exc_code=0.
- R9: All outputs are 0 while rst_n is low. After reset, each output shows the result for the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| base_use | input | 1 | Include the base register in the offset |
| base_val | input | 32 | Base register value |
| index_use | input | 1 | Include the scaled index in the offset |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp | input | 32 | Displacement |
| acc_size | input | 2 | Access length in bytes minus one |
| seg_para | input | 16 | Real-mode segment paragraph number |
| desc_base | input | 32 | Descriptor segment base |
| desc_limit | input | 20 | Descriptor segment limit |
| desc_gran | input | 1 | Descriptor granularity, 1 = limit in 4 KB units |
| desc_present | input | 1 | Descriptor present bit |
| lin_addr | output | 32 | Linear address |
| gp_fault | output | 1 | Limit violation (exception 13) |
| np_fault | output | 1 | Segment not present (exception 11) |
| exc_code | output | 8 | Exception number, 0 when no fault |

## Verification
The sweep builds each target offset from several combinations, so that a broken term in the offset sum shows up as a wrong address:
- index plus displacement;
- base plus scaled index;
- base plus scaled index plus displacement;
- base plus displacement.

The target offsets are placed one below, at and one above the last legal start for every access size, which separates an off-by-one error in the limit compare from a wrong access-size term. The index carries high set bits and the segment bases sit near the top of the address space. This exposes a shift or an add that fails to wrap modulo 2^32. The sweep crosses both modes with every setting of the granularity and present bits, including a limit that covers the whole space. This shows whether the descriptor bits are ignored in real mode and whether not-present takes priority in protected mode.

// File: rtl/sag_pkg.sv
package sag_pkg;
   localparam int EXC_W = 8;
   typedef enum logic [EXC_W-1:0] {
      EXC_NONE = 8'd0,
      EXC_NP   = 8'd11,
      EXC_GP   = 8'd13
   } exc_e;
endpackage

// File: rtl/sag_offset.sv
module sag_offset #(
   parameter int AW   = 32,
   parameter int SC_W = 2
) (
   input  logic          base_use,
   input  logic [AW-1:0] base_val,
   input  logic          index_use,
   input  logic [AW-1:0] index_val,
   input  logic [SC_W-1:0] scale_code,
   input  logic [AW-1:0] disp,
   output logic [AW-1:0] offset
);
   localparam int N_SCALE = 1 << SC_W;

   logic [AW-1:0] shifted [N_SCALE];
   logic [AW-1:0] idx_term;
   logic [AW-1:0] base_term;

   // one pre-shifted copy per scale code; the code selects among them
   for (genvar s = 0; s < N_SCALE; s++) begin : g_shift
      assign shifted[s] = index_val << s;
   end

   always_comb begin
      idx_term  = index_use ? shifted[scale_code] : '0;
      base_term = base_use  ? base_val : '0;
      offset    = base_term + idx_term + disp;
   end
endmodule

// File: rtl/sag_seg_base.sv
module sag_seg_base #(
   parameter int AW         = 32,
   parameter int SEG_W      = 16,
   parameter int PARA_SHIFT = 4
) (
   input  logic             prot_mode,
   input  logic [SEG_W-1:0] seg_para,
   input  logic [AW-1:0]    desc_base,
   output logic [AW-1:0]    seg_base
);
   localparam int PARA_W = SEG_W + PARA_SHIFT;

   if (PARA_W > AW) begin : g_bad_para
      $error("sag_seg_base: paragraph base does not fit the address width");
   end

   logic [AW-1:0] real_base;
   assign real_base = AW'({seg_para, {PARA_SHIFT{1'b0}}});

   always_comb begin
      seg_base = prot_mode ? desc_base : real_base;
   end
endmodule

// File: rtl/sag_limit.sv
module sag_limit #(
   parameter int AW         = 32,
   parameter int LIM_W      = 20,
   parameter int PAGE_SHIFT = 12,
   parameter int REAL_LIM_W = 16,
   parameter int SZ_W       = 2
) (
   input  logic             prot_mode,
   input  logic [AW-1:0]    offset,
   input  logic [SZ_W-1:0]  acc_size,
   input  logic [LIM_W-1:0] desc_limit,
   input  logic             desc_gran,
   input  logic             desc_present,
   output logic             gp_hit,
   output logic             np_hit
);
   localparam int EW = AW + 1;

   if (LIM_W + PAGE_SHIFT > AW) begin : g_bad_gran
      $error("sag_limit: scaled limit does not fit the address width");
   end
   if (REAL_LIM_W > AW) begin : g_bad_real
      $error("sag_limit: real-mode limit wider than the address");
   end

   logic [AW-1:0] eff_lim;
   logic [EW-1:0] last_byte;

   always_comb begin
      if (!prot_mode)
         eff_lim = AW'({REAL_LIM_W{1'b1}});
      else if (desc_gran)
         eff_lim = AW'({desc_limit, {PAGE_SHIFT{1'b1}}});
      else
         eff_lim = AW'(desc_limit);
      // one extra bit keeps the end of the access from wrapping past zero
      last_byte = {1'b0, offset} + EW'(acc_size);
      np_hit    = prot_mode && !desc_present;
      gp_hit    = !np_hit && (last_byte > {1'b0, eff_lim});
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int AW         = 32,
   parameter int SEG_W      = 16,
   parameter int LIM_W      = 20,
   parameter int SC_W       = 2,
   parameter int SZ_W       = 2,
   parameter int PARA_SHIFT = 4,
   parameter int PAGE_SHIFT = 12,
   parameter int REAL_LIM_W = 16,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prot_mode,
   input  logic             base_use,
   input  logic [AW-1:0]    base_val,
   input  logic             index_use,
   input  logic [AW-1:0]    index_val,
   input  logic [SC_W-1:0]  scale_code,
   input  logic [AW-1:0]    disp,
   input  logic [SZ_W-1:0]  acc_size,
   input  logic [SEG_W-1:0] seg_para,
   input  logic [AW-1:0]    desc_base,
   input  logic [LIM_W-1:0] desc_limit,
   input  logic             desc_gran,
   input  logic             desc_present,
   output logic [AW-1:0]    lin_addr,
   output logic             gp_fault,
   output logic             np_fault,
   output logic [sag_pkg::EXC_W-1:0] exc_code
);
   import sag_pkg::*;

   if (AW < 8) begin : g_bad_aw
      $error("seg_addr_gen: address width too small");
   end

   logic [AW-1:0] off_c;
   logic [AW-1:0] seg_base_c;
   logic [AW-1:0] lin_c;
   logic          gp_c, np_c;
   exc_e          exc_c;

   sag_offset #(.AW(AW), .SC_W(SC_W)) u_off (
      .base_use  (base_use),
      .base_val  (base_val),
      .index_use (index_use),
      .index_val (index_val),
      .scale_code(scale_code),
      .disp      (disp),
      .offset    (off_c)
   );

   sag_seg_base #(.AW(AW), .SEG_W(SEG_W), .PARA_SHIFT(PARA_SHIFT)) u_base (
      .prot_mode(prot_mode),
      .seg_para (seg_para),
      .desc_base(desc_base),
      .seg_base (seg_base_c)
   );

   sag_limit #(
      .AW(AW), .LIM_W(LIM_W), .PAGE_SHIFT(PAGE_SHIFT),
      .REAL_LIM_W(REAL_LIM_W), .SZ_W(SZ_W)
   ) u_lim (
      .prot_mode   (prot_mode),
      .offset      (off_c),
      .acc_size    (acc_size),
      .desc_limit  (desc_limit),
      .desc_gran   (desc_gran),
      .desc_present(desc_present),
      .gp_hit      (gp_c),
      .np_hit      (np_c)
   );

   always_comb begin
      lin_c = seg_base_c + off_c;
      if (np_c)      exc_c = EXC_NP;
      else if (gp_c) exc_c = EXC_GP;
      else           exc_c = EXC_NONE;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lin_addr <= '0;
            gp_fault <= 1'b0;
            np_fault <= 1'b0;
            exc_code <= EXC_NONE;
         end else begin
            lin_addr <= lin_c;
            gp_fault <= gp_c;
            np_fault <= np_c;
            exc_code <= exc_c;
         end
      end

      // R7
      np_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
         np_fault |-> (!gp_fault && exc_code == EXC_NP));
      // R6
      gp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gp_fault |-> (exc_code == EXC_GP));
      // R8
      clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!gp_fault && !np_fault) |-> (exc_code == EXC_NONE));
      // R3
      real_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(prot_mode) |-> !np_fault);
      // R5
      full_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(prot_mode) && $past(desc_present) && $past(desc_gran)
          && ($past(desc_limit) == {LIM_W{1'b1}}) && ($past(acc_size) == '0))
         |-> !gp_fault);
   end else begin : g_comb
      assign lin_addr = lin_c;
      assign gp_fault = gp_c;
      assign np_fault = np_c;
      assign exc_code = exc_c;
   end
endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_mode = 0, base_use = 0, index_use = 0;
   logic [31:0] base_val = 0, index_val = 0, disp = 0, desc_base = 0;
   logic [1:0]  scale_code = 0, acc_size = 0;
   logic [15:0] seg_para = 0;
   logic [19:0] desc_limit = 0;
   logic        desc_gran = 0, desc_present = 0;
   logic [31:0] lin_addr;
   logic        gp_fault, np_fault;
   logic [7:0]  exc_code;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
      .base_use(base_use), .base_val(base_val),
      .index_use(index_use), .index_val(index_val),
      .scale_code(scale_code), .disp(disp), .acc_size(acc_size),
      .seg_para(seg_para), .desc_base(desc_base), .desc_limit(desc_limit),
      .desc_gran(desc_gran), .desc_present(desc_present),
      .lin_addr(lin_addr), .gp_fault(gp_fault), .np_fault(np_fault),
      .exc_code(exc_code)
   );

   task automatic compare(input string tag, input logic [31:0] e_lin,
                          input logic e_gp, input logic e_np, input logic [7:0] e_exc);
      n_vec++;
      if (lin_addr !== e_lin || gp_fault !== e_gp || np_fault !== e_np || exc_code !== e_exc) begin
         n_bad++;
         $display("FAIL %s: lin=%h gp=%b np=%b exc=%0d expected lin=%h gp=%b np=%b exc=%0d",
                  tag, lin_addr, gp_fault, np_fault, exc_code, e_lin, e_gp, e_np, e_exc);
      end
   endtask

   // drive one vector at a falling edge, check it at the next falling edge
   task automatic run(input logic pm, input logic bu, input logic [31:0] bv,
                      input logic iu, input logic [31:0] iv, input logic [1:0] sc,
                      input logic [31:0] d, input logic [1:0] sz, input logic [15:0] sp,
                      input logic [31:0] db, input logic [19:0] dl,
                      input logic g, input logic p);
      logic [31:0] off, lim, e_lin;
      logic [32:0] last;
      logic e_np, e_gp;
      logic [7:0] e_exc;
      string tag;
      @(negedge clk);
      prot_mode = pm; base_use = bu; base_val = bv; index_use = iu;
      index_val = iv; scale_code = sc; disp = d; acc_size = sz;
      seg_para = sp; desc_base = db; desc_limit = dl;
      desc_gran = g; desc_present = p;
      // R1 offset sum with wrap
      off = (bu ? bv : 32'd0) + (iu ? (iv * (32'd1 << sc)) : 32'd0) + d;
      // R5 effective limit, R3 fixed 64 KB limit in real mode
      lim = pm ? (g ? ({12'd0, dl} * 32'd4096 + 32'd4095) : {12'd0, dl}) : 32'h0000_FFFF;
      last = {1'b0, off} + {31'd0, sz};
      e_np = pm && !p;
      e_gp = !e_np && (last > {1'b0, lim});
      e_exc = e_np ? 8'd11 : (e_gp ? 8'd13 : 8'd0);
      e_lin = pm ? (db + off) : ({16'd0, sp} * 32'd16 + off);
      if (e_np)      tag = "R7";
      else if (e_gp) tag = pm ? "R6 R5" : "R3";
      else           tag = pm ? "R4 R5 R1 R8" : "R2 R1 R8";
      @(negedge clk);
      compare(tag, e_lin, e_gp, e_np, e_exc);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      prot_mode = 1; desc_base = 32'hDEAD_BEEF; base_use = 1; base_val = 32'h1234;
      repeat (3) @(negedge clk);
      // R9 reset state
      compare("R9 reset", 32'd0, 1'b0, 1'b0, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 latency: a new vector must not reach the outputs before a rising edge
      run(1, 1, 32'h10, 0, 0, 0, 32'h20, 0, 0, 32'h1000, 20'h00100, 0, 1);
      @(negedge clk);
      prot_mode = 1; desc_base = 32'h5000; base_val = 32'h40;
      #1;
      compare("R9 hold", 32'h1030, 1'b0, 1'b0, 8'd0);
      @(negedge clk);
      compare("R9 update", 32'h5060, 1'b0, 1'b0, 8'd0);

      for (int pm = 0; pm < 2; pm++)
       for (int form = 0; form < 4; form++)
        for (int sc = 0; sc < 4; sc++)
         for (int sz = 0; sz < 4; sz++)
          for (int g = 0; g < 2; g++)
           for (int p = 0; p < 2; p++)
            for (int ls = 0; ls < 2; ls++)
             for (int dt = 0; dt < 3; dt++) begin
                logic [19:0] dl;
                logic [31:0] lim, t, iv, scaled, bv, d;
                logic bu, iu;
                dl  = ls ? 20'hFFFFF : 20'h00ABC;
                lim = pm ? (g ? ({12'd0, dl} * 32'd4096 + 32'd4095) : {12'd0, dl}) : 32'h0000_FFFF;
                // offsets one below, at and one above the last legal start
                t   = lim - 32'(sz) + 32'(dt) - 32'd1;
                iv  = 32'hC000_0005 + 32'(dt);
                scaled = iv * (32'd1 << sc);
                case (form)
                   0: begin bu = 0; iu = 1; bv = 32'hFFFF_FFFF; d = t - scaled; end
                   1: begin bu = 1; iu = 1; bv = t - scaled; d = 0; end
                   2: begin bu = 1; iu = 1; bv = 32'h100; d = t - scaled - 32'h100; end
                   default: begin bu = 1; iu = 0; bv = 32'h7; d = t - 32'h7; end
                endcase
                run(pm[0], bu, bv, iu, iv, sc[1:0], d, sz[1:0],
                    16'hF120 + 16'(sc), 32'hFFFF_F000 + 32'(form), dl, g[0], p[0]);
             end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule